// File: doc/BRIEF.md
# Timed Two-Slot Transmit Arbiter

This block picks which of two pending transmit slots is handed to the protocol engine. Each slot has a valid flag, a 64-bit launch time, an identifier in register layout and a flag marking the identifier as extended. A slot may be offered only once the free-running time input has reached its launch time, so a frame leaves at a scheduled instant rather than as soon as it is written.

When both slots are eligible, the earlier launch time wins. On equal launch times, bus priority decides. Each identifier is first turned into a plain 29-bit number. A base identifier sits in the top 11 bits of that number, so it ranks against extended identifiers as it would on the wire.

The winner's metadata is registered once per clock and frozen while the engine holds its lock input. A confirmation input names the slot that was consumed. That slot is then withheld until its valid flag drops, so a sent frame is not offered a second time.

Top module: `tx_sched_arbiter`

## Requirements
- R1: While rst_n is low at a clock edge, frame_avail_o, sel_o, sel_id_o, sel_ext_o and sel_ts_o all become 0.
- R2: A slot is eligible only when its valid input is high and now_i >= its launch time, compared as unsigned 64-bit values. A launch time equal to now_i is eligible.
- R3: When exactly one slot is eligible, that slot is selected whatever its identifier (sel_o = 0 for slot 0, 1 for slot 1).
- R4: When both slots are eligible and their launch times differ, the slot with the smaller launch time is selected.
- R5: When both are eligible with equal launch times, the lower numeric identifier wins. Register layout puts the base part in bits [10:0] and the extension in bits [28:11]. The numeric value of an extended identifier is {reg[10:0], reg[28:11]}. The numeric value of a base identifier is {reg[10:0], 18'b0}.
- R6: When launch times and numeric identifiers are both equal, a base identifier wins over an extended one. If the two slots are otherwise identical, slot 0 wins.
- R7: frame_avail_o is 0 whenever no slot is eligible. Otherwise it is 1, and sel_id_o, sel_ext_o and sel_ts_o equal the selected slot's inputs, with the identifier in register layout.
- R8: Outputs reflect the inputs present at the previous rising edge (one register stage). While lock_i is high at an edge, every output keeps its value.
- R9: A high confirm_i at an edge marks slot confirm_idx_i as consumed. A consumed slot is not eligible until its valid input has been seen low at an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_i | input | 1 | Engine is transmitting; freeze outputs |
| now_i | input | 64 | Current time |
| b0_valid_i | input | 1 | Slot 0 holds a frame |
| b0_ts_i | input | 64 | Slot 0 launch time |
| b0_id_i | input | 29 | Slot 0 identifier, register layout |
| b0_ext_i | input | 1 | Slot 0 identifier is extended |
| b1_valid_i | input | 1 | Slot 1 holds a frame |
| b1_ts_i | input | 64 | Slot 1 launch time |
| b1_id_i | input | 29 | Slot 1 identifier, register layout |
| b1_ext_i | input | 1 | Slot 1 identifier is extended |
| confirm_i | input | 1 | Engine consumed a slot |
| confirm_idx_i | input | 1 | Index of the consumed slot |
| frame_avail_o | output | 1 | A frame is offered |
| sel_o | output | 1 | Index of offered slot |
| sel_id_o | output | 29 | Offered identifier, register layout |
| sel_ext_o | output | 1 | Offered identifier is extended |
| sel_ts_o | output | 64 | Offered launch time |

## Verification
The bench places the current time one tick before a launch time, then exactly at it. A strict comparison would hold the frame back one tick too long, and a loose one would release it early. It also sets a launch time with only the top bit set, where a signed compare would release the frame at once. The identifier ties use pairs whose raw register values order the opposite way from their numeric values, and a base identifier against an extended one with the same upper bits. A design that skipped the layout conversion or the alignment would pick the wrong slot. The lock, confirm and valid-drop sequences expose designs that update under a lock or offer a consumed frame again.

// File: rtl/tx_arb_pkg.sv
// Shared constants for the timed transmit arbiter.
// Assumes exactly two slots; slot index fits in one bit.
package tx_arb_pkg;
    localparam int NUM_SLOTS = 2;
    typedef enum logic {SLOT_0 = 1'b0, SLOT_1 = 1'b1} slot_e;
endpackage

// File: rtl/tx_id_normalize.sv
// Turns a register-layout identifier into a numeric priority key.
// Assumes the base part sits in the low BASE_W bits and the extension above it;
// a base identifier is aligned to the top of the key space.
module tx_id_normalize #(
    parameter int ID_W   = 29,
    parameter int BASE_W = 11
) (
    input  logic [ID_W-1:0] id_reg_i,
    input  logic            ext_i,
    output logic [ID_W-1:0] key_o
);
    localparam int EXT_W = ID_W - BASE_W;

    // Reorder the fields into bus priority order.
    always_comb begin
        if (ext_i)
            key_o = {id_reg_i[BASE_W-1:0], id_reg_i[ID_W-1:BASE_W]};
        else
            key_o = {id_reg_i[BASE_W-1:0], {EXT_W{1'b0}}};
    end
endmodule

// File: rtl/tx_slot_gate.sv
// Decides whether one slot may be offered right now.
// Assumes both times are unsigned and share one time base.
module tx_slot_gate #(
    parameter int TS_W = 64
) (
    input  logic [TS_W-1:0] now_i,
    input  logic [TS_W-1:0] ts_i,
    input  logic            valid_i,
    input  logic            consumed_i,
    output logic            elig_o
);
    // Eligible once the launch time is reached and the slot is not spent.
    always_comb elig_o = valid_i && !consumed_i && (now_i >= ts_i);
endmodule

// File: rtl/tx_pick.sv
// Chooses the winner between two slots: earliest launch time, then lowest key,
// then base format, then slot 0.
// Assumes keys are already normalised to bus priority order.
module tx_pick #(
    parameter int TS_W  = 64,
    parameter int KEY_W = 29
) (
    input  logic [1:0]       elig_i,
    input  logic [TS_W-1:0]  ts0_i,
    input  logic [TS_W-1:0]  ts1_i,
    input  logic [KEY_W-1:0] key0_i,
    input  logic [KEY_W-1:0] key1_i,
    input  logic             ext0_i,
    input  logic             ext1_i,
    output logic             any_o,
    output logic             win_o
);
    // Priority decision over the two candidates.
    always_comb begin
        any_o = |elig_i;
        win_o = 1'b0;
        unique case (elig_i)
            2'b10:   win_o = 1'b1;
            2'b11: begin
                if (ts1_i != ts0_i)
                    win_o = (ts1_i < ts0_i);
                else if (key1_i != key0_i)
                    win_o = (key1_i < key0_i);
                else
                    win_o = ext0_i && !ext1_i;
            end
            default: win_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/tx_sched_arbiter.sv
// Timed two-slot transmit arbiter. Registers the chosen slot's metadata once
// per clock, holds it under lock_i, and withholds a confirmed slot until its
// valid flag drops. Assumes synchronous active-low reset.
module tx_sched_arbiter
    import tx_arb_pkg::*;
#(
    parameter int TS_W   = 64,
    parameter int ID_W   = 29,
    parameter int BASE_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lock_i,
    input  logic [TS_W-1:0] now_i,
    input  logic            b0_valid_i,
    input  logic [TS_W-1:0] b0_ts_i,
    input  logic [ID_W-1:0] b0_id_i,
    input  logic            b0_ext_i,
    input  logic            b1_valid_i,
    input  logic [TS_W-1:0] b1_ts_i,
    input  logic [ID_W-1:0] b1_id_i,
    input  logic            b1_ext_i,
    input  logic            confirm_i,
    input  logic            confirm_idx_i,
    output logic            frame_avail_o,
    output logic            sel_o,
    output logic [ID_W-1:0] sel_id_o,
    output logic            sel_ext_o,
    output logic [TS_W-1:0] sel_ts_o
);
    logic [NUM_SLOTS-1:0]  valid_v;
    logic [NUM_SLOTS-1:0]  ext_v;
    logic [TS_W-1:0]       ts_v   [NUM_SLOTS];
    logic [ID_W-1:0]       id_v   [NUM_SLOTS];
    logic [ID_W-1:0]       key_v  [NUM_SLOTS];
    logic [NUM_SLOTS-1:0]  elig;
    logic [NUM_SLOTS-1:0]  consumed_q;
    logic                  any_w;
    logic                  win_w;
    slot_e                 win_s;

    // Gather the per-slot inputs into arrays.
    always_comb begin
        valid_v = {b1_valid_i, b0_valid_i};
        ext_v   = {b1_ext_i, b0_ext_i};
        ts_v[0] = b0_ts_i;
        ts_v[1] = b1_ts_i;
        id_v[0] = b0_id_i;
        id_v[1] = b1_id_i;
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_lane
        tx_id_normalize #(.ID_W(ID_W), .BASE_W(BASE_W)) u_norm (
            .id_reg_i (id_v[g]),
            .ext_i    (ext_v[g]),
            .key_o    (key_v[g])
        );
        tx_slot_gate #(.TS_W(TS_W)) u_gate (
            .now_i      (now_i),
            .ts_i       (ts_v[g]),
            .valid_i    (valid_v[g]),
            .consumed_i (consumed_q[g]),
            .elig_o     (elig[g])
        );

        // Track whether this slot was already sent; a low valid re-arms it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                consumed_q[g] <= 1'b0;
            else if (!valid_v[g])
                consumed_q[g] <= 1'b0;
            else if (confirm_i && (confirm_idx_i == 1'(g)))
                consumed_q[g] <= 1'b1;
        end
    end

    tx_pick #(.TS_W(TS_W), .KEY_W(ID_W)) u_pick (
        .elig_i (elig),
        .ts0_i  (ts_v[0]),
        .ts1_i  (ts_v[1]),
        .key0_i (key_v[0]),
        .key1_i (key_v[1]),
        .ext0_i (ext_v[0]),
        .ext1_i (ext_v[1]),
        .any_o  (any_w),
        .win_o  (win_w)
    );

    always_comb win_s = slot_e'(win_w);

    // Register the winner's metadata unless the engine holds the lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_avail_o <= 1'b0;
            sel_o         <= 1'b0;
            sel_id_o      <= '0;
            sel_ext_o     <= 1'b0;
            sel_ts_o      <= '0;
        end else if (!lock_i) begin
            frame_avail_o <= any_w;
            sel_o         <= win_w;
            sel_id_o      <= any_w ? id_v[win_s]  : '0;
            sel_ext_o     <= any_w ? ext_v[win_s] : 1'b0;
            sel_ts_o      <= any_w ? ts_v[win_s]  : '0;
        end
    end

    // R8: lock freezes the offer.
    p_lock_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(lock_i)) |->
            ($stable(frame_avail_o) && $stable(sel_o) && $stable(sel_ts_o)));

    // R2: an offered frame's launch time was already reached.
    p_time_reached_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(lock_i) && frame_avail_o) |->
            (sel_ts_o <= $past(now_i)));

    // R7: an offered slot was valid.
    p_avail_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(lock_i) && frame_avail_o) |->
            (sel_o ? $past(b1_valid_i) : $past(b0_valid_i)));

    // R3: a lone eligible slot is chosen.
    p_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(lock_i) && $past(elig) == 2'b01) |->
            (frame_avail_o && !sel_o));

    // R4: earliest launch time wins.
    p_earliest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(lock_i) && $past(elig) == 2'b11 &&
         $past(b0_ts_i) != $past(b1_ts_i)) |->
            (sel_ts_o == (($past(b0_ts_i) < $past(b1_ts_i)) ?
                          $past(b0_ts_i) : $past(b1_ts_i))));

    // R9: a consumed slot is not offered.
    p_consumed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(lock_i) && $past(consumed_q[0])) |->
            !(frame_avail_o && !sel_o));
endmodule

// File: tb/tx_sched_arbiter_bench.sv
module tx_sched_arbiter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lock_i = 1'b0;
    logic [63:0] now_i = '0;
    logic        b0_valid_i = 1'b0, b1_valid_i = 1'b0;
    logic [63:0] b0_ts_i = '0, b1_ts_i = '0;
    logic [28:0] b0_id_i = '0, b1_id_i = '0;
    logic        b0_ext_i = 1'b0, b1_ext_i = 1'b0;
    logic        confirm_i = 1'b0, confirm_idx_i = 1'b0;
    logic        frame_avail_o, sel_o, sel_ext_o;
    logic [28:0] sel_id_o;
    logic [63:0] sel_ts_o;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    tx_sched_arbiter u_tx_sched_arbiter (
        .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .now_i(now_i),
        .b0_valid_i(b0_valid_i), .b0_ts_i(b0_ts_i), .b0_id_i(b0_id_i), .b0_ext_i(b0_ext_i),
        .b1_valid_i(b1_valid_i), .b1_ts_i(b1_ts_i), .b1_id_i(b1_id_i), .b1_ext_i(b1_ext_i),
        .confirm_i(confirm_i), .confirm_idx_i(confirm_idx_i),
        .frame_avail_o(frame_avail_o), .sel_o(sel_o), .sel_id_o(sel_id_o),
        .sel_ext_o(sel_ext_o), .sel_ts_o(sel_ts_o)
    );

    function automatic logic [28:0] base_id(input logic [10:0] b);
        return {18'b0, b};
    endfunction

    function automatic logic [28:0] ext_id(input logic [10:0] b, input logic [17:0] e);
        return {e, b};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_slots();
        b0_valid_i = 0; b1_valid_i = 0; b0_ext_i = 0; b1_ext_i = 0;
        b0_ts_i = 0; b1_ts_i = 0; b0_id_i = 0; b1_id_i = 0;
        step();
    endtask

    task automatic t_reset();
        rst_n = 0;
        b0_valid_i = 1; b0_ts_i = 0; b0_id_i = base_id(11'h7);
        step(); step();
        check("R1", "avail", 64'(frame_avail_o), 0);
        check("R1", "sel", 64'(sel_o), 0);
        check("R1", "ts", sel_ts_o, 0);
        check("R1", "id", 64'(sel_id_o), 0);
        rst_n = 1;
        clear_slots();
    endtask

    task automatic t_time_gate();
        b0_valid_i = 1; b0_ts_i = 64'd1000; b0_id_i = base_id(11'h12);
        now_i = 64'd999;
        step();
        check("R2", "avail before launch", 64'(frame_avail_o), 0);
        now_i = 64'd1000;
        step();
        check("R2", "avail at launch", 64'(frame_avail_o), 1);
        check("R7", "ts copy", sel_ts_o, 64'd1000);
        check("R7", "id copy", 64'(sel_id_o), 64'(base_id(11'h12)));
        b0_ts_i = 64'h8000_0000_0000_0000; now_i = 64'd1;
        step();
        check("R2", "unsigned compare", 64'(frame_avail_o), 0);
        b0_valid_i = 0; b0_ts_i = 0;
        step();
        check("R7", "invalid slot idle", 64'(frame_avail_o), 0);
        clear_slots();
    endtask

    task automatic t_single();
        now_i = 64'd500;
        b0_valid_i = 1; b0_ts_i = 64'd100; b0_id_i = base_id(11'h001);
        b1_valid_i = 1; b1_ts_i = 64'd600; b1_id_i = base_id(11'h7FF);
        step();
        check("R3", "future slot1 skipped", 64'(sel_o), 0);
        b0_valid_i = 0;
        b1_ts_i = 64'd400;
        step();
        check("R3", "lone slot1 sel", 64'(sel_o), 1);
        check("R3", "lone slot1 avail", 64'(frame_avail_o), 1);
        check("R7", "lone slot1 id", 64'(sel_id_o), 64'(base_id(11'h7FF)));
        clear_slots();
    endtask

    task automatic t_earliest();
        now_i = 64'd500;
        b0_valid_i = 1; b0_ts_i = 64'd300; b0_id_i = base_id(11'h001);
        b1_valid_i = 1; b1_ts_i = 64'd200; b1_id_i = base_id(11'h7FF);
        step();
        check("R4", "earlier slot1", 64'(sel_o), 1);
        check("R4", "earlier ts", sel_ts_o, 64'd200);
        b0_ts_i = 64'd150;
        step();
        check("R4", "earlier slot0", 64'(sel_o), 0);
        clear_slots();
    endtask

    task automatic t_id_tie();
        now_i = 64'd200;
        b0_valid_i = 1; b0_ts_i = 64'd100; b0_ext_i = 1; b0_id_i = ext_id(11'h100, 18'h3);
        b1_valid_i = 1; b1_ts_i = 64'd100; b1_ext_i = 1; b1_id_i = ext_id(11'h100, 18'h2);
        step();
        check("R5", "lower extension", 64'(sel_o), 1);
        b0_id_i = ext_id(11'h001, 18'h3FFFF);
        b1_id_i = ext_id(11'h002, 18'h0);
        step();
        check("R5", "numeric not raw", 64'(sel_o), 0);
        check("R7", "ext flag", 64'(sel_ext_o), 1);
        b0_ext_i = 0; b0_id_i = base_id(11'h010);
        b1_ext_i = 1; b1_id_i = ext_id(11'h00F, 18'h3FFFF);
        step();
        check("R5", "base aligned high", 64'(sel_o), 1);
        clear_slots();
    endtask

    task automatic t_format_tie();
        now_i = 64'd200;
        b0_valid_i = 1; b0_ts_i = 64'd50; b0_ext_i = 1; b0_id_i = ext_id(11'h055, 18'h0);
        b1_valid_i = 1; b1_ts_i = 64'd50; b1_ext_i = 0; b1_id_i = base_id(11'h055);
        step();
        check("R6", "base beats ext", 64'(sel_o), 1);
        check("R6", "base flag", 64'(sel_ext_o), 0);
        b0_ext_i = 0; b0_id_i = base_id(11'h055);
        step();
        check("R6", "identical slot0", 64'(sel_o), 0);
        clear_slots();
    endtask

    task automatic t_lock();
        now_i = 64'd500;
        b0_valid_i = 1; b0_ts_i = 64'd300; b0_id_i = base_id(11'h1);
        b1_valid_i = 1; b1_ts_i = 64'd200; b1_id_i = base_id(11'h2);
        step();
        check("R8", "pre-lock sel", 64'(sel_o), 1);
        lock_i = 1; b0_ts_i = 64'd10;
        step();
        check("R8", "held sel", 64'(sel_o), 1);
        check("R8", "held ts", sel_ts_o, 64'd200);
        b0_valid_i = 0; b1_valid_i = 0;
        step();
        check("R8", "held avail", 64'(frame_avail_o), 1);
        lock_i = 0; b0_valid_i = 1;
        step();
        check("R8", "post-lock sel", 64'(sel_o), 0);
        check("R8", "post-lock ts", sel_ts_o, 64'd10);
        clear_slots();
    endtask

    task automatic t_confirm();
        now_i = 64'd500;
        b0_valid_i = 1; b0_ts_i = 64'd100; b0_id_i = base_id(11'h1);
        b1_valid_i = 1; b1_ts_i = 64'd200; b1_id_i = base_id(11'h2);
        step();
        check("R9", "before confirm", 64'(sel_o), 0);
        confirm_i = 1; confirm_idx_i = 0;
        step();
        confirm_i = 0;
        step();
        check("R9", "slot0 withheld", 64'(sel_o), 1);
        check("R9", "slot1 offered", 64'(frame_avail_o), 1);
        confirm_i = 1; confirm_idx_i = 1;
        step();
        confirm_i = 0;
        step();
        check("R9", "both withheld", 64'(frame_avail_o), 0);
        b0_valid_i = 0;
        step();
        b0_valid_i = 1;
        step();
        check("R9", "slot0 re-armed avail", 64'(frame_avail_o), 1);
        check("R9", "slot0 re-armed sel", 64'(sel_o), 0);
        clear_slots();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_time_gate();
        t_single();
        t_earliest();
        t_id_tie();
        t_format_tie();
        t_lock();
        t_confirm();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #2000000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule